// File: doc/BRIEF.md
# Serial Fast Command Decoder

The block takes a single-bit command line sampled on every edge of a fast clock and turns it into a framed control stream. Frames are eight bits long, most significant bit first. Each frame starts with the sync prefix `110` and ends with a stop bit of `1`. The four bits in between are command flags. The decoder searches for the bit offset at which frames carry a correct prefix and stop bit. It declares lock once enough consecutive frames agree at that offset. From then on it emits a one-cycle frame-phase pulse and widens each decoded flag into a strobe one frame long. One frame equals one period of the slow bunch clock.

While hunting, the decoder checks one candidate window per frame. After every failed window it shifts the next window one bit later. Once locked, it tolerates isolated corrupt frames and drops lock only after a run of them. An idle frame with no flags set still counts as a valid frame. It therefore keeps the phase alive.

The lock behaviour is set by a state machine with four named states:
- `ST_HUNT`: nothing found yet.
- `ST_CONFIRM`: counting consecutive good frames.
- `ST_LOCKED`: aligned.
- `ST_HOLDOVER`: still locked, but counting consecutive bad frames.

The transitions are:
- hunt-to-confirm on a good frame.
- confirm-to-hunt on a bad frame.
- confirm-to-locked on the `LOCK_FRAMES`-th good frame.
- locked-to-holdover on a bad frame.
- holdover-to-locked on a good frame.
- holdover-to-hunt on the `UNLOCK_FRAMES`-th bad frame.

Top module: `fcd_fast_cmd_decoder`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `locked`, `phase40`, all four command strobes and `cmd_error` are 0.
- R2: A frame is eight consecutive samples of `sdi`, the first sample landing in frame bit 7. The frame is valid only when bits 7..5 equal `110` and bit 0 equals 1.
- R3: From reset or after losing lock, `locked` rises in the cycle after the last bit of the `LOCK_FRAMES`-th consecutive valid frame (default 4). While unlocked, an invalid frame makes the next candidate window start one bit later, so the next check comes nine cycles after the failed one.
- R4: When locked, `locked` falls in the cycle after the last bit of the `UNLOCK_FRAMES`-th consecutive invalid frame (default 3). A valid frame in between restarts that count.
- R5: Bit 4 of a frame drives `cmd_fast_reset`, bit 3 `cmd_trigger`, bit 2 `cmd_test_pulse` and bit 1 `cmd_orbit_reset`. A strobe is high for exactly eight cycles, starting in the cycle after the frame's last bit. It is high only for a valid frame that arrives while `locked` is already 1.
- R6: `cmd_error` is high for the same eight cycles when such a frame has two or more of bits 4, 3 and 2 set. The flags of that frame are still driven individually.
- R7: `phase40` is a one-cycle pulse in the cycle after the last bit of every frame checked while `locked` was 1. While lock is held, the pulses are exactly eight cycles apart.
- R8: A frame with a wrong prefix or stop bit, received while locked, produces no strobe and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock, one edge per serial bit |
| rst_n | input | 1 | Synchronous active-low reset |
| sdi | input | 1 | Serial command bit |
| phase40 | output | 1 | One-cycle recovered frame-phase pulse |
| locked | output | 1 | Frame alignment established |
| cmd_fast_reset | output | 1 | Fast reset strobe, one frame wide |
| cmd_trigger | output | 1 | Trigger strobe, one frame wide |
| cmd_test_pulse | output | 1 | Test-pulse trigger strobe, one frame wide |
| cmd_orbit_reset | output | 1 | Orbit reset strobe, one frame wide |
| cmd_error | output | 1 | Frame carried a flag combination outside the legal set |

## Verification
The properties assume that `sdi` changes only between sampling edges. They also assume reset is held for at least one edge, so the frame slot and the lock state start from a known point. The stimulus keeps to this by driving `sdi` on the falling edge from a single task. Frames are sent back to back, with a deliberate short run of stray bits only where the alignment search is meant to be exercised. Lock is always first acquired on idle frames. No bit rotation of the idle frame passes the sync and stop test, so the search cannot settle on a false offset.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int FRAME_W = 8;

    localparam int SYNC_HI  = 7;
    localparam int SYNC_LO  = 5;
    localparam logic [2:0] SYNC_CODE = 3'b110;
    localparam int STOP_POS = 0;

    localparam int FLAG_FAST_RESET  = 4;
    localparam int FLAG_TRIGGER     = 3;
    localparam int FLAG_TEST_PULSE  = 2;
    localparam int FLAG_ORBIT_RESET = 1;

    typedef enum logic [1:0] {
        ST_HUNT     = 2'd0,
        ST_CONFIRM  = 2'd1,
        ST_LOCKED   = 2'd2,
        ST_HOLDOVER = 2'd3
    } lock_state_e;

    typedef struct packed {
        logic fast_reset;
        logic trigger;
        logic test_pulse;
        logic orbit_reset;
    } cmd_flags_t;

endpackage

// File: rtl/fcd_deserializer.sv
module fcd_deserializer
    import fcd_pkg::*;
#(
    parameter int W = FRAME_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sdi,
    output logic [W-1:0] word
);

    logic [W-2:0] hist_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[W-3:0], sdi};
        end
    end

    // oldest sample lands in the MSB, current sample in the LSB
    assign word = {hist_q, sdi};

endmodule

// File: rtl/fcd_bit_slot.sv
module fcd_bit_slot
    import fcd_pkg::*;
#(
    parameter int W = FRAME_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slip,
    output logic tick
);

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] slot_q;
    logic          skip_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            skip_q <= 1'b0;
        end else if (skip_q) begin
            // hold slot 0 one extra cycle: window moves one bit later
            skip_q <= 1'b0;
        end else if (slot_q == LAST) begin
            slot_q <= '0;
            skip_q <= slip;
        end else begin
            slot_q <= slot_q + 1'b1;
        end
    end

    assign tick = !skip_q && (slot_q == LAST);

endmodule

// File: rtl/fcd_cmd_decode.sv
module fcd_cmd_decode
    import fcd_pkg::*;
(
    input  logic [FRAME_W-1:0] word,
    output logic               frame_ok,
    output cmd_flags_t         flags,
    output logic               combo_err
);

    logic [1:0] excl_cnt;

    always_comb begin
        frame_ok          = (word[SYNC_HI:SYNC_LO] == SYNC_CODE) && word[STOP_POS];
        flags.fast_reset  = word[FLAG_FAST_RESET];
        flags.trigger     = word[FLAG_TRIGGER];
        flags.test_pulse  = word[FLAG_TEST_PULSE];
        flags.orbit_reset = word[FLAG_ORBIT_RESET];
        excl_cnt = 2'({1'b0, flags.fast_reset}) + 2'({1'b0, flags.trigger})
                 + 2'({1'b0, flags.test_pulse});
        combo_err = (excl_cnt >= 2'd2);
    end

endmodule

// File: rtl/fcd_lock_fsm.sv
module fcd_lock_fsm
    import fcd_pkg::*;
#(
    parameter int LOCK_FRAMES   = 4,
    parameter int UNLOCK_FRAMES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic frame_ok,
    output logic locked,
    output logic slip,
    output logic accept,
    output logic phase_hit
);

    localparam int GW = $clog2(LOCK_FRAMES + 1);
    localparam int BW = $clog2(UNLOCK_FRAMES + 1);
    localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_FRAMES - 1);
    localparam logic [BW-1:0] BAD_LAST  = BW'(UNLOCK_FRAMES - 1);

    lock_state_e   state_q, state_d;
    logic [GW-1:0] good_q, good_d;
    logic [BW-1:0] bad_q, bad_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            good_q  <= '0;
            bad_q   <= '0;
        end else begin
            state_q <= state_d;
            good_q  <= good_d;
            bad_q   <= bad_d;
        end
    end

    always_comb begin
        state_d = state_q;
        good_d  = good_q;
        bad_d   = bad_q;
        if (tick) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (frame_ok) begin
                        state_d = ST_CONFIRM;
                        good_d  = GW'(1);
                    end
                end
                ST_CONFIRM: begin
                    if (!frame_ok) begin
                        state_d = ST_HUNT;
                        good_d  = '0;
                    end else if (good_q == GOOD_LAST) begin
                        state_d = ST_LOCKED;
                        good_d  = '0;
                    end else begin
                        good_d  = good_q + 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (!frame_ok) begin
                        state_d = ST_HOLDOVER;
                        bad_d   = BW'(1);
                    end
                end
                ST_HOLDOVER: begin
                    if (frame_ok) begin
                        state_d = ST_LOCKED;
                        bad_d   = '0;
                    end else if (bad_q == BAD_LAST) begin
                        state_d = ST_HUNT;
                        bad_d   = '0;
                    end else begin
                        bad_d   = bad_q + 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        locked    = (state_q == ST_LOCKED) || (state_q == ST_HOLDOVER);
        slip      = tick && !frame_ok && !locked;
        accept    = tick && frame_ok && locked;
        phase_hit = tick && locked;
    end

endmodule

// File: rtl/fcd_fast_cmd_decoder.sv
module fcd_fast_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int LOCK_FRAMES   = 4,
    parameter int UNLOCK_FRAMES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sdi,
    output logic phase40,
    output logic locked,
    output logic cmd_fast_reset,
    output logic cmd_trigger,
    output logic cmd_test_pulse,
    output logic cmd_orbit_reset,
    output logic cmd_error
);

    logic [FRAME_W-1:0] word;
    logic               tick;
    logic               slip;
    logic               frame_ok;
    logic               combo_err;
    logic               accept;
    logic               phase_hit;
    cmd_flags_t         flags;
    cmd_flags_t         strobe_q;
    logic               err_q;
    logic               phase_q;

    fcd_deserializer #(.W(FRAME_W)) u_deser (
        .clk   (clk),
        .rst_n (rst_n),
        .sdi   (sdi),
        .word  (word)
    );

    fcd_bit_slot #(.W(FRAME_W)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .slip  (slip),
        .tick  (tick)
    );

    fcd_cmd_decode u_dec (
        .word      (word),
        .frame_ok  (frame_ok),
        .flags     (flags),
        .combo_err (combo_err)
    );

    fcd_lock_fsm #(
        .LOCK_FRAMES   (LOCK_FRAMES),
        .UNLOCK_FRAMES (UNLOCK_FRAMES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .frame_ok  (frame_ok),
        .locked    (locked),
        .slip      (slip),
        .accept    (accept),
        .phase_hit (phase_hit)
    );

    // strobes are reloaded only at a frame check, so each lasts one frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= '0;
            err_q    <= 1'b0;
            phase_q  <= 1'b0;
        end else begin
            phase_q <= phase_hit;
            if (tick) begin
                strobe_q <= accept ? flags : '0;
                err_q    <= accept && combo_err;
            end
        end
    end

    always_comb begin
        phase40         = phase_q;
        cmd_fast_reset  = strobe_q.fast_reset;
        cmd_trigger     = strobe_q.trigger;
        cmd_test_pulse  = strobe_q.test_pulse;
        cmd_orbit_reset = strobe_q.orbit_reset;
        cmd_error       = err_q;
    end

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
    import fcd_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic phase40,
    input logic locked,
    input logic cmd_fast_reset,
    input logic cmd_trigger,
    input logic cmd_test_pulse,
    input logic cmd_orbit_reset,
    input logic cmd_error
);

    localparam int SW = $clog2(FRAME_W + 1) + 1;

    logic [4:0]    strobes;
    logic [SW-1:0] since_q;
    logic          seen_q;

    assign strobes = {cmd_fast_reset, cmd_trigger, cmd_test_pulse, cmd_orbit_reset, cmd_error};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (phase40) begin
            since_q <= '0;
            seen_q  <= locked;
        end else begin
            if (since_q != {SW{1'b1}}) since_q <= since_q + 1'b1;
            if (!locked) seen_q <= 1'b0;
        end
    end

    // R5: strobes change only on a frame-phase pulse
    assert_strobe_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(strobes) |-> phase40);

    // R5: nothing is issued while lock is absent
    assert_quiet_unlocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !$past(locked)) |-> (strobes == '0));

    // R6: error needs at least two exclusive flags
    assert_error_combo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_error |-> ($countones({cmd_fast_reset, cmd_trigger, cmd_test_pulse}) >= 2));

    // R7: phase pulses follow a locked cycle
    assert_phase_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        phase40 |-> $past(locked));

    // R7: spacing of one frame while lock is held
    assert_phase_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase40 && seen_q) |-> (since_q == SW'(FRAME_W - 1)));

    // R3: the locking frame itself issues no pulse
    assert_lock_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (!phase40 && strobes == '0));

endmodule

bind fcd_fast_cmd_decoder fcd_checker u_fcd_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .phase40         (phase40),
    .locked          (locked),
    .cmd_fast_reset  (cmd_fast_reset),
    .cmd_trigger     (cmd_trigger),
    .cmd_test_pulse  (cmd_test_pulse),
    .cmd_orbit_reset (cmd_orbit_reset),
    .cmd_error       (cmd_error)
);

// File: tb/test_fcd_fast_cmd_decoder.sv
module test_fcd_fast_cmd_decoder;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CLK_PERIOD = 4;
    localparam int LOCK_N     = 4;
    localparam int UNLOCK_N   = 3;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sdi = 1'b0;
    logic phase40, locked, cmd_fast_reset, cmd_trigger, cmd_test_pulse, cmd_orbit_reset, cmd_error;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    fcd_fast_cmd_decoder #(.LOCK_FRAMES(LOCK_N), .UNLOCK_FRAMES(UNLOCK_N)) i_fcd_fast_cmd_decoder (
        .clk             (clk),
        .rst_n           (rst_n),
        .sdi             (sdi),
        .phase40         (phase40),
        .locked          (locked),
        .cmd_fast_reset  (cmd_fast_reset),
        .cmd_trigger     (cmd_trigger),
        .cmd_test_pulse  (cmd_test_pulse),
        .cmd_orbit_reset (cmd_orbit_reset),
        .cmd_error       (cmd_error)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // behavioural reference
    int   m_pos = 0;
    bit   m_skip = 0;
    int   m_hist [$];
    int   m_st = 0;      // 0 hunt, 1 confirm, 2 locked, 3 holdover
    int   m_good = 0;
    int   m_bad = 0;
    logic e_locked = 0, e_phase = 0, e_fr = 0, e_trg = 0, e_tp = 0, e_orb = 0, e_err = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_skip = 0; m_hist.delete(); m_st = 0; m_good = 0; m_bad = 0;
            e_locked = 0; e_phase = 0; e_fr = 0; e_trg = 0; e_tp = 0; e_orb = 0; e_err = 0;
        end else begin
            m_hist.push_back(int'(sdi));
            if (m_hist.size() > 8) void'(m_hist.pop_front());
            e_phase = 0;
            if (m_skip) begin
                m_skip = 0;
            end else if (m_pos == 7) begin
                int  b [8];
                bit  ok, was_locked;
                int  excl;
                m_pos = 0;
                for (int i = 0; i < 8; i++) b[7 - i] = (m_hist.size() == 8) ? m_hist[i] : 0;
                if (m_hist.size() < 8)
                    for (int i = 0; i < m_hist.size(); i++) b[m_hist.size() - 1 - i] = m_hist[i];
                ok = (b[7] == 1) && (b[6] == 1) && (b[5] == 0) && (b[0] == 1);
                was_locked = (m_st >= 2);
                e_phase = was_locked;
                excl = b[4] + b[3] + b[2];
                if (ok && was_locked) begin
                    e_fr = b[4][0]; e_trg = b[3][0]; e_tp = b[2][0]; e_orb = b[1][0];
                    e_err = (excl >= 2);
                end else begin
                    e_fr = 0; e_trg = 0; e_tp = 0; e_orb = 0; e_err = 0;
                end
                if (!ok && !was_locked) m_skip = 1;
                case (m_st)
                    0: if (ok) begin m_st = 1; m_good = 1; end
                    1: if (!ok) begin m_st = 0; m_good = 0; end
                       else if (m_good + 1 == LOCK_N) begin m_st = 2; m_good = 0; end
                       else m_good++;
                    2: if (!ok) begin m_st = 3; m_bad = 1; end
                    default: if (ok) begin m_st = 2; m_bad = 0; end
                       else if (m_bad + 1 == UNLOCK_N) begin m_st = 0; m_bad = 0; end
                       else m_bad++;
                endcase
            end else begin
                m_pos++;
            end
            e_locked = (m_st >= 2);
        end
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 R4", "locked", locked, e_locked);
            check("R7", "phase40", phase40, e_phase);
            check("R5 R8", "cmd_fast_reset", cmd_fast_reset, e_fr);
            check("R5 R8", "cmd_trigger", cmd_trigger, e_trg);
            check("R5 R8", "cmd_test_pulse", cmd_test_pulse, e_tp);
            check("R5 R8", "cmd_orbit_reset", cmd_orbit_reset, e_orb);
            check("R6", "cmd_error", cmd_error, e_err);
        end
    end

    task automatic send_bit(input logic v);
        @(negedge clk);
        sdi = v;
    endtask

    // R2: frame bit 7 goes out first
    task automatic send_frame(input logic [7:0] f);
        for (int i = 7; i >= 0; i--) send_bit(f[i]);
    endtask

    task automatic send_idle(input int n);
        for (int i = 0; i < n; i++) send_frame(8'hC1);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R1", "locked in reset", locked, 1'b0);
        check("R1", "strobes in reset",
              phase40 | cmd_fast_reset | cmd_trigger | cmd_test_pulse | cmd_orbit_reset | cmd_error, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "locked after release", locked, 1'b0);

        // R3: misaligned start, hunt by single-bit slips, then lock on idle
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        send_idle(20);
        check("R3", "locked after idle run", locked, 1'b1);

        // R5, R6: single, combined and illegal flag sets
        send_frame(8'hD1); send_frame(8'hC9); send_frame(8'hC5); send_frame(8'hC3);
        send_frame(8'hD3); send_frame(8'hCB); send_frame(8'hC7); send_frame(8'hC1);
        send_frame(8'hD9); send_frame(8'hCD); send_frame(8'hDF); send_idle(1);

        // R8: bad prefix and bad stop while locked, then recovery
        send_frame(8'hE9); send_frame(8'hC8); send_frame(8'hC9);
        check("R4", "lock held through short burst", locked, 1'b1);
        send_frame(8'h00); send_frame(8'h00); send_frame(8'hC9);
        send_idle(1);

        // R4: a full run of bad frames drops lock
        send_frame(8'h00); send_frame(8'hFF); send_frame(8'h00);
        @(negedge clk);
        check("R4", "lock lost", locked, 1'b0);
        send_frame(8'hC9);

        // R3: broken confirmation, then new offset
        send_idle(2); send_frame(8'h00);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        send_idle(20);
        check("R3", "relocked at new offset", locked, 1'b1);
        send_frame(8'hC9); send_frame(8'hC3); send_idle(3);

        finish_run();
    end

endmodule